// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block is a 32-pin general-purpose I/O port controlled through a simple register bus: an address, a write strobe, write data and a combinational read data return. Software never performs a read-modify-write on the output levels. It writes a mask to a set register to drive pins high, or to a clear register to drive pins low. Either of these writes also makes the selected pins outputs. A third register, the release register, returns selected pins to input mode and leaves their output latches untouched.

The pin levels come back through a two-flop synchronizer and a read-only level register. Input sampling is disarmed after reset. The level register reads as zero until software has written the arm register once, and the value of that write does not matter. Each pin has an output level, an output-enable and an input. The pad itself is outside the block, and so are interrupts and pin multiplexing.

Top module: `sc_gpio_port`

## Requirements
- R1: After a synchronous active-low reset, every output-enable bit is 0, every output latch is 0 and input sampling is disarmed. The level register at offset 0x0C therefore reads 0 whatever the pins carry.
- R2: A write to offset 0x00 sets the output latch of each pin whose write-data bit is 1. Other latches keep their value. The change is visible on the output pins after the next clock edge.
- R3: A write to offset 0x04 clears the output latch of each pin whose write-data bit is 1. Other latches keep their value. The change is visible after the next clock edge.
- R4: A write to offset 0x00 or 0x04 also sets the output-enable of each selected pin. The output-enable of unselected pins is unchanged.
- R5: A write to offset 0x08 clears the output-enable of each selected pin. It changes no output latch and no output-enable of an unselected pin.
- R6: Once sampling is armed, bit i of a read at offset 0x0C is the level pin i had two clock edges earlier, through a two-stage synchronizer.
- R7: A write of any value, including 0, to offset 0x10 arms input sampling from the next clock edge. Sampling stays armed until reset. Before that write, offset 0x0C reads 0.
- R8: A read at any offset other than 0x0C returns 0, including the offsets that only accept writes. A write to 0x0C or to an unmapped offset changes no output latch, no output-enable and no arm state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data (pin mask) |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 32 | Levels seen at the pins |
| pin_out | output | 32 | Output latch per pin |
| pin_oe | output | 32 | Output-enable per pin, 1 drives the pin |

## Verification
The output latches, the output-enables and the arm flag change at the clock edge that takes the write. The bench therefore samples them at the falling edge after that rising edge. A new pin level reaches the level register only after two rising edges. The bench holds the pin inputs steady for at least two edges before it reads offset 0x0C. One directed case reads after one edge, where the old level is still expected, and again after the second edge. Read data is combinational, so a read is sampled a short time after the address settles, well clear of the next rising edge.

// File: rtl/sc_gpio_pkg.sv
// Shared constants and types of the set/clear GPIO port.
// Assumes byte offsets on a word-aligned register bus.
package sc_gpio_pkg;

    localparam int unsigned BUS_DATA_W = 32;
    localparam int unsigned BUS_ADDR_W = 5;

    localparam int unsigned OFS_SET   = 32'h00;
    localparam int unsigned OFS_CLR   = 32'h04;
    localparam int unsigned OFS_REL   = 32'h08;
    localparam int unsigned OFS_LEVEL = 32'h0C;
    localparam int unsigned OFS_ARM   = 32'h10;

    // One-cycle write strobes produced by the decoder
    typedef struct packed {
        logic drive_hi;
        logic drive_lo;
        logic release_p;
        logic arm_in;
    } wr_strobe_t;

endpackage

// File: rtl/sc_gpio_sync.sv
// Multi-stage synchronizer for the pin inputs.
// Assumes the inputs are asynchronous to clk; every stage resets to 0.
module sc_gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                // capture the raw pin levels
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[k] <= '0;
                    else        stage_q[k] <= din;
                end
            end else begin : g_next
                // move the level one stage along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[k] <= '0;
                    else        stage_q[k] <= stage_q[k-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R6: output follows the input two edges later
            a_r6_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n, 2) && $past(rst_n)) |-> (dout == $past(din, 2)));
        end
    endgenerate

endmodule

// File: rtl/sc_gpio_drive.sv
// Per-pin output latch and output-enable.
// Assumes at most one strobe is active per cycle (the decoder guarantees it).
module sc_gpio_drive
    import sc_gpio_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  wr_strobe_t      strobe,
    input  logic [PINS-1:0] mask,
    output logic [PINS-1:0] lvl,
    output logic [PINS-1:0] oe
);

    logic [PINS-1:0] lvl_q;
    logic [PINS-1:0] oe_q;

    genvar i;
    generate
        for (i = 0; i < PINS; i++) begin : g_pin
            // update one pin's latch and direction from the strobes
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_q[i] <= 1'b0;
                    oe_q[i]  <= 1'b0;
                end else if (mask[i]) begin
                    if (strobe.drive_hi) begin
                        lvl_q[i] <= 1'b1;
                        oe_q[i]  <= 1'b1;
                    end else if (strobe.drive_lo) begin
                        lvl_q[i] <= 1'b0;
                        oe_q[i]  <= 1'b1;
                    end else if (strobe.release_p) begin
                        oe_q[i]  <= 1'b0;
                    end
                end
            end
        end
    endgenerate

    assign lvl = lvl_q;
    assign oe  = oe_q;

    // R2: selected latches go high, others keep their value
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.drive_hi |=> (((lvl & $past(mask)) == $past(mask)) &&
                             ((lvl & ~$past(mask)) == ($past(lvl) & ~$past(mask)))));
    // R3: selected latches go low, others keep their value
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.drive_lo |=> (((lvl & $past(mask)) == '0) &&
                             ((lvl & ~$past(mask)) == ($past(lvl) & ~$past(mask)))));
    // R4: set or clear also turns the selected pins into outputs
    a_r4_make_output: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.drive_hi || strobe.drive_lo) |=>
            (((oe & $past(mask)) == $past(mask)) &&
             ((oe & ~$past(mask)) == ($past(oe) & ~$past(mask)))));
    // R5: release clears direction only and keeps every latch
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.release_p |=> (((oe & $past(mask)) == '0) && (lvl == $past(lvl)) &&
                              ((oe & ~$past(mask)) == ($past(oe) & ~$past(mask)))));
    // R8: no strobe, no change
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe.drive_hi || strobe.drive_lo || strobe.release_p) |=>
            ($stable(lvl) && $stable(oe)));

endmodule

// File: rtl/sc_gpio_decode.sv
// Register decoder, input-arm flag and read multiplexer.
// Assumes full-address decode: only the exact byte offsets are mapped.
module sc_gpio_decode
    import sc_gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PINS   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   pin_level,
    output wr_strobe_t        strobe,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_REL   = ADDR_W'(OFS_REL);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);
    localparam logic [ADDR_W-1:0] A_ARM   = ADDR_W'(OFS_ARM);

    logic armed_q;

    // turn a bus write into one strobe
    always_comb begin
        strobe.drive_hi  = bus_wr && (bus_addr == A_SET);
        strobe.drive_lo  = bus_wr && (bus_addr == A_CLR);
        strobe.release_p = bus_wr && (bus_addr == A_REL);
        strobe.arm_in    = bus_wr && (bus_addr == A_ARM);
    end

    // sticky flag set by the first write to the arm register
    always_ff @(posedge clk) begin
        if (!rst_n)             armed_q <= 1'b0;
        else if (strobe.arm_in) armed_q <= 1'b1;
    end

    // return the gated pin levels at the level offset, 0 elsewhere
    always_comb begin
        bus_rdata = '0;
        if ((bus_addr == A_LEVEL) && armed_q) bus_rdata[PINS-1:0] = pin_level;
    end

    // R7: arming takes effect at the next edge and stays
    a_r7_arm_next: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.arm_in |=> armed_q);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> armed_q);
    // R7: disarmed port reads zero everywhere
    a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (bus_rdata == '0));
    // R8: every offset but the level register reads zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != A_LEVEL) |-> (bus_rdata == '0));
    // R8: at most one strobe per cycle
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strobe.drive_hi, strobe.drive_lo, strobe.release_p, strobe.arm_in}));

endmodule

// File: rtl/sc_gpio_port.sv
// Set/clear GPIO port: 32 pins behind a five-register bus.
// Assumes PINS <= DATA_W; write data bit i addresses pin i.
module sc_gpio_port
    import sc_gpio_pkg::*;
#(
    parameter int unsigned PINS        = 32,
    parameter int unsigned ADDR_W      = BUS_ADDR_W,
    parameter int unsigned DATA_W      = BUS_DATA_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);

    logic [PINS-1:0] pin_sync;
    wr_strobe_t      strobe;

    sc_gpio_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    sc_gpio_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PINS   (PINS)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .pin_level (pin_sync),
        .strobe    (strobe),
        .bus_rdata (bus_rdata)
    );

    sc_gpio_drive #(
        .PINS (PINS)
    ) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .mask   (bus_wdata[PINS-1:0]),
        .lvl    (pin_out),
        .oe     (pin_oe)
    );

    // R1: the cycle after reset, nothing is driven
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0 && !$isunknown($past(rst_n, 2))
        |-> (pin_oe == '0 && pin_out == '0));

endmodule

// File: tb/sc_gpio_port_test.sv
module sc_gpio_port_test;

    localparam logic [4:0] O_SET = 5'h00, O_CLR = 5'h04, O_REL = 5'h08,
                           O_LVL = 5'h0C, O_ARM = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] m_lvl, m_oe;
    bit          m_arm;

    always #10 clk = ~clk;

    sc_gpio_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected model updated from the requirements
    task automatic model_write(input logic [4:0] a, input logic [31:0] d);
        case (a)
            O_SET: begin m_lvl = m_lvl | d;  m_oe = m_oe | d; end
            O_CLR: begin m_lvl = m_lvl & ~d; m_oe = m_oe | d; end
            O_REL: m_oe = m_oe & ~d;
            O_ARM: m_arm = 1;
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_level(input bit armed, input logic [31:0] pins);
        return armed ? pins : 32'h0;
    endfunction

    // drive at a falling edge, the write lands on the next rising edge
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_lvl = '0; m_oe = '0; m_arm = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] unm [4];
        int unsigned seed;
        unm[0] = 32'h0C; unm[1] = 32'h14; unm[2] = 32'h1C; unm[3] = 32'h02;
        seed = $urandom(32'h00C0FFEE);

        pin_in = 32'hFFFF_FFFF;
        @(negedge clk);
        do_reset();
        check("R1 pin_out after reset", pin_out, 32'h0);
        check("R1 pin_oe after reset", pin_oe, 32'h0);
        bus_read(O_LVL, rd);
        check("R1 level disarmed after reset", rd, 32'h0);

        repeat (3) @(negedge clk);
        bus_read(O_LVL, rd);
        check("R7 level zero before arm write", rd, 32'h0);

        bus_write(O_ARM, 32'h0);
        bus_read(O_LVL, rd);
        check("R7 armed by write of zero", rd, 32'hFFFF_FFFF);

        bus_write(O_SET, 32'hA5A5_0F0F);
        check("R2 set mask", pin_out, 32'hA5A5_0F0F);
        check("R4 set makes outputs", pin_oe, 32'hA5A5_0F0F);
        bus_write(O_SET, 32'h0000_00F0);
        check("R2 set keeps others", pin_out, 32'hA5A5_0FFF);
        bus_write(O_CLR, 32'h0000_0F00);
        check("R3 clear mask", pin_out, 32'hA5A5_00FF);
        check("R4 clear makes outputs", pin_oe, 32'hA5A5_0FFF);
        bus_write(O_REL, 32'hFFFF_0000);
        check("R5 release direction", pin_oe, 32'h0000_0FFF);
        check("R5 release keeps latches", pin_out, 32'hA5A5_00FF);

        pin_in = 32'h1234_5678;
        @(negedge clk);
        bus_read(O_LVL, rd);
        check("R6 one edge still old", rd, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_read(O_LVL, rd);
        check("R6 two edges new level", rd, 32'h1234_5678);

        bus_read(O_SET, rd); check("R8 read set offset", rd, 32'h0);
        bus_read(O_CLR, rd); check("R8 read clear offset", rd, 32'h0);
        bus_read(O_REL, rd); check("R8 read release offset", rd, 32'h0);
        bus_read(O_ARM, rd); check("R8 read arm offset", rd, 32'h0);
        bus_read(5'h14, rd); check("R8 read unmapped", rd, 32'h0);
        bus_read(5'h0D, rd); check("R8 read misaligned", rd, 32'h0);

        bus_write(O_LVL, 32'hFFFF_FFFF);
        bus_write(5'h14, 32'hFFFF_FFFF);
        bus_write(5'h01, 32'hFFFF_FFFF);
        check("R8 ignored writes keep latches", pin_out, 32'hA5A5_00FF);
        check("R8 ignored writes keep direction", pin_oe, 32'h0000_0FFF);

        do_reset();
        @(negedge clk);
        bus_read(O_LVL, rd);
        check("R1 reset disarms sampling", rd, 32'h0);
        check("R1 reset clears latches", pin_out, 32'h0);
        bus_write(5'h14, 32'h0);
        @(negedge clk);
        bus_read(O_LVL, rd);
        check("R8 unmapped write does not arm", rd, 32'h0);

        for (int n = 0; n < 400; n++) begin
            int unsigned op;
            logic [4:0]  a;
            logic [31:0] d;
            op = $urandom % 8;
            d = $urandom;
            case (op)
                0, 1: a = O_SET;
                2, 3: a = O_CLR;
                4, 5: a = O_REL;
                6:    a = (($urandom % 6) == 0) ? O_ARM : O_REL;
                default: a = unm[$urandom % 4];
            endcase
            pin_in = $urandom;
            bus_write(a, d);
            @(negedge clk);
            check("R2 R3 random latches", pin_out, m_lvl);
            check("R4 R5 random direction", pin_oe, m_oe);
            bus_read(O_LVL, rd);
            check("R6 R7 random level", rd, exp_level(m_arm, pin_in));
        end

        finish_run();
    end

endmodule